// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the register-facing command front end of an SD/eMMC-style host controller. Software first writes a 32-bit argument. It then writes a 16-bit command word, and that write launches the command. The upper byte of the command word holds the command index. The lower byte holds flags that select the response kind, the CRC check, the index check, data presence and the command type. The unit presents the latched command and argument to a card-line engine with a one-cycle start pulse. The engine's completion strobes then drive a write-one-to-clear interrupt status register.

Which event marks completion depends on the command. A plain command finishes when its response arrives. A command that carries data, or that waits out a busy period, stays active until the engine reports transfer complete. A failed CRC or index check ends the command at once, and a single summary bit reports the failure in place of either completion bit. A self-clearing software reset register aborts the command and clears the status bits that belong to the circuit being reset.

All register addresses are word addresses. The map is: argument 0, command 1, response words 4 to 7, interrupt status 8, software reset 9, present state 10.

Top module: `sdh_cmd_issue`

## Requirements
- R1: After reset, every readable register (argument, command, responses, status, reset, present state) reads 0 and `engStart` is low.
- R2: A write to word 1 while idle launches a command. In the next cycle `engStart` is high for exactly one cycle, `engCmdWord` equals the written bits [15:0] (index in [15:8], flags in [7:0]), `engArg` equals the last value written to word 0, and present-state bit 0 reads 1.
- R3: Flags [1:0] select the response kind: 00 none, 01 136-bit, 10 48-bit, 11 48-bit plus busy. When the response arrives, kind 00 leaves the response words unchanged. A 48-bit kind stores `engRsp[31:0]` in word 4. Kind 01 stores `engRsp[32k+31:32k]` in word 4+k for k = 0..3.
- R4: A command without data (flag bit 5 = 0) and not of kind 11 sets status bit 0 on `engCmdDone` and returns to idle (present state 0).
- R5: A command with flag bit 5 set, or of kind 11, sets status bit 0 on `engCmdDone`. It then keeps present-state bits 0 and 1 set until `engXferDone`, which sets status bit 1 and returns it to idle.
- R6: A `dmaIrq` pulse sets status bit 3.
- R7: Writing word 8 clears each status bit whose written bit is 1 and leaves the other bits unchanged.
- R8: A write to word 1 while a command is active is ignored. No start pulse is issued and `engCmdWord` is unchanged.
- R9: With flag bit 4 set and a response present, an `engRspIndex` that differs from the command index sets status bits 17 and 15, does not set bit 0, and ends the command. With flag bit 4 clear, a mismatch has no effect.
- R10: With flag bit 3 set and a response present, `engRspCrcBad` sets status bits 16 and 15 and ends the command without waiting for a transfer. With flag bit 3 clear, it has no effect.
- R11: Status bit 15 reads 1 exactly while bit 16 or bit 17 is set, and drops when both are cleared.
- R12: Writing word 9 with bit 1 (command reset) and/or bit 2 (data reset) set aborts any active command. Each written bit reads back 1 for RST_CYCLES cycles and then clears. A command reset clears status bits 0, 16 and 17, and a data reset clears bits 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write word address |
| wrData | input | 32 | Register write data |
| rdAddr | input | ADDR_W | Register read word address |
| rdData | output | 32 | Register read data (combinational) |
| engStart | output | 1 | One-cycle command launch pulse to the card-line engine |
| engCmdWord | output | 16 | Latched command index and flags |
| engArg | output | 32 | Argument register value |
| engCmdDone | input | 1 | Engine strobe: command sent and response (if any) received |
| engRspIndex | input | 8 | Index field of the received response |
| engRspCrcBad | input | 1 | Engine flag: received response failed CRC |
| engRsp | input | 128 | Received response bits |
| engXferDone | input | 1 | Engine strobe: data transfer or busy period finished |
| dmaIrq | input | 1 | DMA boundary event strobe |

## Verification
A wrong control state shows up within one cycle in present-state bits 0 and 1. A unit stuck active refuses the next launch, so no start pulse appears and `engCmdWord` stays stale. A unit that returns to idle too early shows status bit 0 without bit 1 on a data or busy command, and the bench reads that right after the engine strobe. A wrong error decision appears on the status read that follows the response: bit 15 with bit 16 or 17 appears without bit 0, or is missing. A wrong word-enable in the response store shows up only when a later 48-bit response leaves words 5 to 7 at their earlier values.

// File: rtl/sdh_cmd_pkg.sv
package sdh_cmd_pkg;

  localparam int DATA_W    = 32;
  localparam int CMD_W     = 16;
  localparam int RSP_WORDS = 4;

  // word addresses
  localparam int W_ARG  = 0;
  localparam int W_CMD  = 1;
  localparam int W_RSP0 = 4;
  localparam int W_STAT = 8;
  localparam int W_RST  = 9;
  localparam int W_PRES = 10;

  // flag and status bit positions
  localparam int FLAG_CRC  = 3;
  localparam int FLAG_IDX  = 4;
  localparam int FLAG_DATA = 5;
  localparam int ST_CMD    = 0;
  localparam int ST_XFER   = 1;
  localparam int ST_DMA    = 3;
  localparam int ST_ERR    = 15;
  localparam int ST_CRCERR = 16;
  localparam int ST_IDXERR = 17;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_LONG  = 2'b01,
    RSP_SHORT = 2'b10,
    RSP_BUSY  = 2'b11
  } rspKind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RSP,
    S_XFER
  } cmdState_e;

  typedef struct packed {
    logic latchCmd;
    logic storeRsp;
    logic setCmdCmpl;
    logic setXferCmpl;
    logic setCrcErr;
    logic setIdxErr;
    logic clrCmdBits;
    logic clrDataBits;
  } ctlStrb_t;

endpackage

// File: rtl/sdh_cmd_ctrl.sv
module sdh_cmd_ctrl
  import sdh_cmd_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrite,
  input  logic       rstWrite,
  input  logic [1:0] rstBits,
  input  logic [7:0] cmdIdx,
  input  rspKind_e   rspKind,
  input  logic       crcEn,
  input  logic       idxEn,
  input  logic       dataEn,
  input  logic       engCmdDone,
  input  logic [7:0] engRspIndex,
  input  logic       engRspCrcBad,
  input  logic       engXferDone,
  output ctlStrb_t   strb,
  output logic       engStart,
  output logic       cmdBusy,
  output logic       xferBusy,
  output logic       cmdRstBusy,
  output logic       dataRstBusy
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  cmdState_e        state, nextState;
  logic [CNT_W-1:0] cmdCnt, dataCnt;
  logic             cmdRstNow, dataRstNow, abortNow;
  logic             rspPresent, crcErr, idxErr, needsXfer;

  assign cmdRstBusy  = (cmdCnt != '0);
  assign dataRstBusy = (dataCnt != '0);
  assign cmdRstNow   = (rstWrite && rstBits[0]) || cmdRstBusy;
  assign dataRstNow  = (rstWrite && rstBits[1]) || dataRstBusy;
  assign abortNow    = cmdRstNow || dataRstNow;

  assign rspPresent = (rspKind != RSP_NONE);
  assign crcErr     = rspPresent && crcEn && engRspCrcBad;
  assign idxErr     = rspPresent && idxEn && (engRspIndex != cmdIdx);
  assign needsXfer  = dataEn || (rspKind == RSP_BUSY);

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (cmdWrite) begin
        strb.latchCmd = 1'b1;
        nextState     = S_RSP;
      end
      S_RSP: if (engCmdDone) begin
        strb.storeRsp = rspPresent;
        if (crcErr || idxErr) begin
          strb.setCrcErr = crcErr;
          strb.setIdxErr = idxErr;
          nextState      = S_IDLE;
        end else begin
          strb.setCmdCmpl = 1'b1;
          nextState       = needsXfer ? S_XFER : S_IDLE;
        end
      end
      S_XFER: if (engXferDone) begin
        strb.setXferCmpl = 1'b1;
        nextState        = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
    if (abortNow) begin
      strb      = '0;
      nextState = S_IDLE;
    end
    strb.clrCmdBits  = cmdRstNow;
    strb.clrDataBits = dataRstNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      engStart <= 1'b0;
      cmdCnt   <= '0;
      dataCnt  <= '0;
    end else begin
      state    <= nextState;
      engStart <= strb.latchCmd;
      if (rstWrite && rstBits[0]) cmdCnt <= CNT_W'(RST_CYCLES);
      else if (cmdRstBusy)        cmdCnt <= cmdCnt - CNT_W'(1);
      if (rstWrite && rstBits[1]) dataCnt <= CNT_W'(RST_CYCLES);
      else if (dataRstBusy)       dataCnt <= dataCnt - CNT_W'(1);
    end
  end

  assign cmdBusy  = (state != S_IDLE);
  assign xferBusy = (state == S_XFER);

endmodule

// File: rtl/sdh_cmd_dp.sv
module sdh_cmd_dp
  import sdh_cmd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [DATA_W-1:0]           rdData,
  input  ctlStrb_t                    strb,
  input  logic                        dmaIrq,
  input  logic [RSP_WORDS*DATA_W-1:0] engRsp,
  input  logic                        cmdBusy,
  input  logic                        xferBusy,
  input  logic                        cmdRstBusy,
  input  logic                        dataRstBusy,
  output logic [DATA_W-1:0]           argReg,
  output logic [CMD_W-1:0]            cmdReg,
  output logic [DATA_W-1:0]           intStat
);

  localparam logic [DATA_W-1:0] W1C_MASK =
    (DATA_W'(1) << ST_CMD) | (DATA_W'(1) << ST_XFER) | (DATA_W'(1) << ST_DMA) |
    (DATA_W'(1) << ST_CRCERR) | (DATA_W'(1) << ST_IDXERR);
  localparam logic [DATA_W-1:0] CMD_CLR  =
    (DATA_W'(1) << ST_CMD) | (DATA_W'(1) << ST_CRCERR) | (DATA_W'(1) << ST_IDXERR);
  localparam logic [DATA_W-1:0] DATA_CLR =
    (DATA_W'(1) << ST_XFER) | (DATA_W'(1) << ST_DMA);

  logic [DATA_W-1:0]           statReg, statSet, statClr;
  logic [RSP_WORDS*DATA_W-1:0] rspVec;
  logic [RSP_WORDS-1:0]        loadWord;
  logic                        isLong;

  assign isLong = (rspKind_e'(cmdReg[1:0]) == RSP_LONG);

  // word 0 loads for every response, the rest only for a long one
  for (genvar k = 0; k < RSP_WORDS; k++) begin : g_load
    if (k == 0) begin : g_first
      assign loadWord[k] = strb.storeRsp;
    end else begin : g_rest
      assign loadWord[k] = strb.storeRsp && isLong;
    end
  end

  always_comb begin
    statSet = '0;
    statSet[ST_CMD]    = strb.setCmdCmpl;
    statSet[ST_XFER]   = strb.setXferCmpl;
    statSet[ST_DMA]    = dmaIrq;
    statSet[ST_CRCERR] = strb.setCrcErr;
    statSet[ST_IDXERR] = strb.setIdxErr;
    statClr = (wrEn && wrAddr == ADDR_W'(W_STAT)) ? (wrData & W1C_MASK) : '0;
    if (strb.clrCmdBits)  statClr = statClr | CMD_CLR;
    if (strb.clrDataBits) statClr = statClr | DATA_CLR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      argReg  <= '0;
      cmdReg  <= '0;
      statReg <= '0;
      rspVec  <= '0;
    end else begin
      if (wrEn && wrAddr == ADDR_W'(W_ARG)) argReg <= wrData;
      if (strb.latchCmd) cmdReg <= wrData[CMD_W-1:0];
      statReg <= (statReg & ~statClr) | statSet;
      for (int k = 0; k < RSP_WORDS; k++) begin
        if (loadWord[k]) rspVec[k*DATA_W +: DATA_W] <= engRsp[k*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    intStat = statReg;
    intStat[ST_ERR] = statReg[ST_CRCERR] | statReg[ST_IDXERR];
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(W_ARG))  rdData = argReg;
    if (rdAddr == ADDR_W'(W_CMD))  rdData = DATA_W'(cmdReg);
    if (rdAddr == ADDR_W'(W_STAT)) rdData = intStat;
    if (rdAddr == ADDR_W'(W_RST))  rdData = DATA_W'({dataRstBusy, cmdRstBusy, 1'b0});
    if (rdAddr == ADDR_W'(W_PRES)) rdData = DATA_W'({xferBusy, cmdBusy});
    for (int k = 0; k < RSP_WORDS; k++) begin
      if (rdAddr == ADDR_W'(W_RSP0 + k)) rdData = rspVec[k*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/sdh_cmd_issue.sv
module sdh_cmd_issue
  import sdh_cmd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [DATA_W-1:0]           rdData,
  output logic                        engStart,
  output logic [CMD_W-1:0]            engCmdWord,
  output logic [DATA_W-1:0]           engArg,
  input  logic                        engCmdDone,
  input  logic [7:0]                  engRspIndex,
  input  logic                        engRspCrcBad,
  input  logic [RSP_WORDS*DATA_W-1:0] engRsp,
  input  logic                        engXferDone,
  input  logic                        dmaIrq
);

  ctlStrb_t          strb;
  logic              cmdBusy, xferBusy, cmdRstBusy, dataRstBusy, rstBusy;
  logic [DATA_W-1:0] intStat;

  assign rstBusy = cmdRstBusy | dataRstBusy;

  sdh_cmd_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdWrite    (wrEn && wrAddr == ADDR_W'(W_CMD)),
    .rstWrite    (wrEn && wrAddr == ADDR_W'(W_RST)),
    .rstBits     (wrData[2:1]),
    .cmdIdx      (engCmdWord[15:8]),
    .rspKind     (rspKind_e'(engCmdWord[1:0])),
    .crcEn       (engCmdWord[FLAG_CRC]),
    .idxEn       (engCmdWord[FLAG_IDX]),
    .dataEn      (engCmdWord[FLAG_DATA]),
    .engCmdDone  (engCmdDone),
    .engRspIndex (engRspIndex),
    .engRspCrcBad(engRspCrcBad),
    .engXferDone (engXferDone),
    .strb        (strb),
    .engStart    (engStart),
    .cmdBusy     (cmdBusy),
    .xferBusy    (xferBusy),
    .cmdRstBusy  (cmdRstBusy),
    .dataRstBusy (dataRstBusy)
  );

  sdh_cmd_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .strb       (strb),
    .dmaIrq     (dmaIrq),
    .engRsp     (engRsp),
    .cmdBusy    (cmdBusy),
    .xferBusy   (xferBusy),
    .cmdRstBusy (cmdRstBusy),
    .dataRstBusy(dataRstBusy),
    .argReg     (engArg),
    .cmdReg     (engCmdWord),
    .intStat    (intStat)
  );

endmodule

// File: rtl/sdh_cmd_chk.sv
module sdh_cmd_chk
  import sdh_cmd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              engStart,
  input logic [CMD_W-1:0]  engCmdWord,
  input logic              cmdBusy,
  input logic              xferBusy,
  input logic              rstBusy,
  input logic              stXfer,
  input logic              stCrcErr,
  input logic              stIdxErr
);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> cmdBusy);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBusy && wrEn && wrAddr == ADDR_W'(W_CMD)) |=> $stable(engCmdWord));

  // R5
  xfer_from_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stXfer) |-> $past(xferBusy));

  // R9
  idx_err_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stIdxErr) |-> ($past(cmdBusy) && !cmdBusy));

  // R10
  crc_err_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stCrcErr) |-> ($past(cmdBusy) && !cmdBusy && !xferBusy));

  // R12
  reset_aborts_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstBusy |-> !cmdBusy);

endmodule

bind sdh_cmd_issue sdh_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .engStart  (engStart),
  .engCmdWord(engCmdWord),
  .cmdBusy   (cmdBusy),
  .xferBusy  (xferBusy),
  .rstBusy   (rstBusy),
  .stXfer    (intStat[1]),
  .stCrcErr  (intStat[16]),
  .stIdxErr  (intStat[17])
);

// File: tb/sim_sdh_cmd_issue.sv
`timescale 1ns/1ps
module sim_sdh_cmd_issue;

  localparam int AW   = 4;
  localparam int RSTC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [31:0]   rdData;
  logic          engStart;
  logic [15:0]   engCmdWord;
  logic [31:0]   engArg;
  logic          engCmdDone = 1'b0;
  logic [7:0]    engRspIndex = '0;
  logic          engRspCrcBad = 1'b0;
  logic [127:0]  engRsp = '0;
  logic          engXferDone = 1'b0;
  logic          dmaIrq = 1'b0;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  sdh_cmd_issue #(.ADDR_W(AW), .RST_CYCLES(RSTC)) u0 (.*);

  typedef struct {
    logic [AW-1:0] addr;
    logic [31:0]   exp;
    string         tag;
  } sbItem_t;

  sbItem_t sbQ[$];
  event    pushEv, doneEv;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected register values and compares them
  initial begin
    forever begin
      @(pushEv);
      while (sbQ.size() > 0) begin
        sbItem_t it;
        it = sbQ[0];
        rdAddr = it.addr;
        #1;
        chk(rdData === it.exp, it.tag, rdData, it.exp);
        void'(sbQ.pop_front());
      end
      ->doneEv;
    end
  end

  task automatic expReg(input logic [AW-1:0] addr, input logic [31:0] exp, input string tag);
    sbItem_t it;
    it.addr = addr; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    ->pushEv;
    @(doneEv);
  endtask

  task automatic wr(input logic [AW-1:0] addr, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cmdDone(input logic [7:0] idx, input bit crcBad, input logic [127:0] rsp);
    @(negedge clk);
    engCmdDone = 1'b1; engRspIndex = idx; engRspCrcBad = crcBad; engRsp = rsp;
    @(negedge clk);
    engCmdDone = 1'b0; engRspCrcBad = 1'b0;
  endtask

  task automatic xferDone();
    @(negedge clk); engXferDone = 1'b1;
    @(negedge clk); engXferDone = 1'b0;
  endtask

  task automatic dmaPulse();
    @(negedge clk); dmaIrq = 1'b1;
    @(negedge clk); dmaIrq = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    failCnt++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(engStart === 1'b0, "R1 engStart", 32'(engStart), 32'h0);
    expReg(0, 32'h0, "R1 argument");
    expReg(1, 32'h0, "R1 command");
    expReg(4, 32'h0, "R1 response0");
    expReg(8, 32'h0, "R1 status");
    expReg(9, 32'h0, "R1 reset reg");
    expReg(10, 32'h0, "R1 present");

    // R2 launch of a 48-bit response command with both checks
    wr(0, 32'h1234_0000);
    wr(1, 32'h0000_071A);
    chk(engStart === 1'b1, "R2 start pulse", 32'(engStart), 32'h1);
    chk(engCmdWord === 16'h071A, "R2 command word", 32'(engCmdWord), 32'h071A);
    chk(engArg === 32'h1234_0000, "R2 argument", engArg, 32'h1234_0000);
    expReg(10, 32'h1, "R2 present busy");

    // R8 second write while active is ignored
    wr(1, 32'h0000_0900);
    chk(engStart === 1'b0, "R8 no start", 32'(engStart), 32'h0);
    chk(engCmdWord === 16'h071A, "R8 word kept", 32'(engCmdWord), 32'h071A);

    // R4 R3 short response completes
    cmdDone(8'h07, 1'b0, {96'h0, 32'hCAFE_0001});
    expReg(8, 32'h1, "R4 status cmd complete");
    expReg(10, 32'h0, "R4 idle");
    expReg(4, 32'hCAFE_0001, "R3 short word0");
    expReg(5, 32'h0, "R3 short word1 untouched");

    // R7 write-one-to-clear
    wr(8, 32'h0000_0002);
    expReg(8, 32'h1, "R7 zero bits keep");
    wr(8, 32'h0000_0001);
    expReg(8, 32'h0, "R7 cleared");

    // R5 busy response type
    wr(1, 32'h0000_061B);
    cmdDone(8'h06, 1'b0, 128'h0);
    expReg(8, 32'h1, "R5 busy: cmd complete only");
    expReg(10, 32'h3, "R5 busy: waiting transfer");
    xferDone();
    expReg(8, 32'h3, "R5 busy: transfer complete");
    expReg(10, 32'h0, "R5 busy: idle");
    wr(8, 32'h3);

    // R5 R6 data command with DMA event
    wr(1, 32'h0000_123A);
    cmdDone(8'h12, 1'b0, 128'h0);
    expReg(10, 32'h3, "R5 data: waiting transfer");
    dmaPulse();
    expReg(8, 32'h9, "R6 dma bit");
    xferDone();
    expReg(8, 32'hB, "R5 data: transfer complete");
    wr(8, 32'hB);

    // R3 long response, index check disabled so mismatch is harmless (R9)
    wr(1, 32'h0000_0909);
    cmdDone(8'h3F, 1'b0, {32'hDDDD_0004, 32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001});
    expReg(8, 32'h1, "R9 index check off");
    expReg(4, 32'hAAAA_0001, "R3 long word0");
    expReg(5, 32'hBBBB_0002, "R3 long word1");
    expReg(6, 32'hCCCC_0003, "R3 long word2");
    expReg(7, 32'hDDDD_0004, "R3 long word3");
    wr(8, 32'h1);

    // R3 no-response command leaves responses
    wr(1, 32'h0000_0000);
    cmdDone(8'h00, 1'b0, {96'h0, 32'h5555_5555});
    expReg(8, 32'h1, "R4 no-response complete");
    expReg(4, 32'hAAAA_0001, "R3 none keeps word0");
    wr(8, 32'h1);

    // R9 index error
    wr(1, 32'h0000_071A);
    cmdDone(8'h3F, 1'b0, 128'h0);
    expReg(8, 32'h0002_8000, "R9 index error");
    expReg(10, 32'h0, "R9 command ended");
    wr(8, 32'h0002_0000);
    expReg(8, 32'h0, "R11 summary drops");

    // R10 CRC error on data command, no transfer wait
    wr(1, 32'h0000_123A);
    cmdDone(8'h12, 1'b1, 128'h0);
    expReg(8, 32'h0001_8000, "R10 crc error");
    expReg(10, 32'h0, "R10 no transfer wait");
    wr(8, 32'h0001_0000);
    expReg(8, 32'h0, "R11 summary drops after crc");

    // R10 CRC check disabled
    wr(1, 32'h0000_0712);
    cmdDone(8'h07, 1'b1, 128'h0);
    expReg(8, 32'h1, "R10 crc check off");

    // R12 software reset aborts and self-clears
    dmaPulse();
    wr(1, 32'h0000_123A);
    expReg(10, 32'h1, "R12 active before reset");
    wr(9, 32'h6);
    expReg(9, 32'h6, "R12 reset in progress");
    expReg(10, 32'h0, "R12 aborted");
    expReg(8, 32'h0, "R12 status cleared");
    repeat (RSTC - 1) @(negedge clk);
    expReg(9, 32'h6, "R12 still in progress");
    @(negedge clk);
    expReg(9, 32'h0, "R12 self cleared");
    wr(1, 32'h0000_0502);
    chk(engStart === 1'b1, "R12 launch after reset", 32'(engStart), 32'h1);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule